// File: doc/BRIEF.md
# Lane-wise Doubleword Shuffle Unit

This SIMD execution unit rearranges the 32-bit elements of a 256-bit operand. An 8-bit order value holds four 2-bit selector fields. Field `i` (bits `2i+1:2i`) chooses which element of a 128-bit source lane lands in element `i` of the matching result lane. A selector value `k` picks the element at bit offset `k*32` inside that lane. No element ever crosses a lane boundary, and the same element may be chosen for several result positions.

A two-bit mode input decides what happens to the upper 128 bits:

- **Merge-128:** the upper half is copied from the previous destination value.
- **Zero-128:** the upper half is forced to zero.
- **Full-256:** the upper half is shuffled from its own source lane, using the same four fields as the lower lane.

A 4-bit reserved field must be all ones in the zeroing and full modes. A wrong value, or the unused mode code, is reported as an illegal encoding, and the result register is left untouched. The result, a valid flag and the illegal flag appear one clock after the input strobe.

Top module: `dw_lane_shuffle`

## Requirements
- R1: Lower lane. One cycle after an accepted strobe, result element `i` (bits `32i+31:32i`, i = 0..3) equals source element `k`, where `k` = order bits `2i+1:2i` (the field at bits 1:0 drives element 0, and bits 7:6 drive element 3).
- R2: Full-256 mode (mode 2'b10, reserved 4'b1111). Result bits 255:128 are built only from source bits 255:128, using the same four order fields as the lower lane.
- R3: Merge-128 mode (mode 2'b00). Result bits 255:128 equal previous-destination bits 255:128. The reserved field is ignored in this mode, so any value gives a valid result.
- R4: Zero-128 mode (mode 2'b01, reserved 4'b1111). Result bits 255:128 are zero.
- R5: Repeated selections are legal. An order such as 8'h00 or 8'hFF broadcasts one source element into all four positions of each shuffled lane.
- R6: Illegal encodings are:
  - mode 2'b11, or
  - mode 2'b01 or 2'b10 with a reserved field other than 4'b1111.

  One cycle after a strobe with an illegal encoding, `out_illegal` is 1 and `out_valid` is 0, and the result register keeps its prior contents.
- R7: Outputs follow the strobe with a latency of one cycle. A cycle without `in_valid` gives `out_valid`=0 and `out_illegal`=0 on the next cycle, and the result is unchanged whatever the other inputs do.
- R8: A synchronous active-high reset clears `out_valid`, `out_illegal` and the result register to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_src | input | 256 | Source operand, two 128-bit lanes |
| in_prev | input | 256 | Previous destination value, used by merge mode |
| in_order | input | 8 | Four 2-bit element selectors |
| in_mode | input | 2 | 00 merge-128, 01 zero-128, 10 full-256, 11 illegal |
| in_rsv | input | 4 | Reserved field, must be 4'b1111 in zero-128 and full-256 |
| out_valid | output | 1 | Result updated this cycle |
| out_illegal | output | 1 | Last strobe carried an illegal encoding |
| out_result | output | 256 | Registered shuffle result |

## Verification
The only internal state is the result register and two flags. A fault in them shows at the ports one clock after the strobe that caused it:

- a wrong selector decode puts a misplaced element in a lane;
- a broken mode mux leaks source or stale bits into the upper half;
- a missing update guard lets an illegal or idle cycle overwrite a held result.

The bench therefore compares every result against an independent lane model on the cycle after each strobe. After illegal and idle cycles, it checks that the held value is still the last legal result.

// File: rtl/shuf_pkg.sv
package shuf_pkg;

    // Mode select encoding
    typedef enum logic [1:0] {
        MODE_MERGE128 = 2'b00,
        MODE_ZERO128  = 2'b01,
        MODE_FULL256  = 2'b10,
        MODE_BAD      = 2'b11
    } mode_e;

    // Source of the lanes above lane 0
    typedef enum logic [1:0] {
        HI_SHUF = 2'b00,
        HI_PREV = 2'b01,
        HI_ZERO = 2'b10
    } hi_src_e;

    typedef struct packed {
        logic    illegal;
        hi_src_e hi_src;
    } dec_t;

    // Modes that demand an all-ones reserved field
    function automatic logic mode_checks_rsv(mode_e m);
        return (m == MODE_ZERO128) || (m == MODE_FULL256);
    endfunction

endpackage

// File: rtl/shuf_lane.sv
module shuf_lane #(
    parameter int ELEM_W     = 32,
    parameter int LANE_ELEMS = 4,
    localparam int SEL_W     = $clog2(LANE_ELEMS),
    localparam int LANE_W    = ELEM_W * LANE_ELEMS,
    localparam int ORD_W     = SEL_W * LANE_ELEMS
) (
    input  logic [LANE_W-1:0] src_lane,
    input  logic [ORD_W-1:0]  order,
    output logic [LANE_W-1:0] dst_lane
);

    for (genvar e = 0; e < LANE_ELEMS; e++) begin : g_elem
        logic [SEL_W-1:0] sel;
        assign sel = order[e*SEL_W +: SEL_W];
        assign dst_lane[e*ELEM_W +: ELEM_W] = src_lane[sel*ELEM_W +: ELEM_W];
    end

endmodule

// File: rtl/shuf_decode.sv
module shuf_decode
    import shuf_pkg::*;
#(
    parameter int RSV_W = 4
) (
    input  logic [1:0]       mode,
    input  logic [RSV_W-1:0] rsv,
    output dec_t             dec
);

    mode_e m;
    logic  rsv_ok;

    assign m      = mode_e'(mode);
    assign rsv_ok = &rsv;

    always_comb begin
        dec.illegal = 1'b0;
        dec.hi_src  = HI_SHUF;
        unique case (m)
            MODE_MERGE128: dec.hi_src = HI_PREV;
            MODE_ZERO128:  dec.hi_src = HI_ZERO;
            MODE_FULL256:  dec.hi_src = HI_SHUF;
            default:       dec.illegal = 1'b1;
        endcase
        if (mode_checks_rsv(m) && !rsv_ok) begin
            dec.illegal = 1'b1;
        end
    end

endmodule

// File: rtl/shuf_hi_mux.sv
module shuf_hi_mux
    import shuf_pkg::*;
#(
    parameter int LANE_W = 128
) (
    input  hi_src_e           hi_src,
    input  logic [LANE_W-1:0] shuf_lane_in,
    input  logic [LANE_W-1:0] prev_lane_in,
    output logic [LANE_W-1:0] lane_out
);

    always_comb begin
        unique case (hi_src)
            HI_PREV: lane_out = prev_lane_in;
            HI_ZERO: lane_out = '0;
            default: lane_out = shuf_lane_in;
        endcase
    end

endmodule

// File: rtl/dw_lane_shuffle.sv
module dw_lane_shuffle
    import shuf_pkg::*;
#(
    parameter int ELEM_W     = 32,
    parameter int LANE_ELEMS = 4,
    parameter int LANES      = 2,
    parameter int RSV_W      = 4,
    localparam int SEL_W     = $clog2(LANE_ELEMS),
    localparam int LANE_W    = ELEM_W * LANE_ELEMS,
    localparam int DATA_W    = LANE_W * LANES,
    localparam int ORD_W     = SEL_W * LANE_ELEMS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_src,
    input  logic [DATA_W-1:0] in_prev,
    input  logic [ORD_W-1:0]  in_order,
    input  logic [1:0]        in_mode,
    input  logic [RSV_W-1:0]  in_rsv,
    output logic              out_valid,
    output logic              out_illegal,
    output logic [DATA_W-1:0] out_result
);

    dec_t              dec;
    logic [DATA_W-1:0] shuf_all;
    logic [DATA_W-1:0] next_result;
    logic              unused_prev_lo;

    // Lane 0 of the previous value is never used
    assign unused_prev_lo = ^in_prev[LANE_W-1:0];

    shuf_decode #(.RSV_W(RSV_W)) u_dec (
        .mode (in_mode),
        .rsv  (in_rsv),
        .dec  (dec)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        shuf_lane #(.ELEM_W(ELEM_W), .LANE_ELEMS(LANE_ELEMS)) u_lane (
            .src_lane (in_src[l*LANE_W +: LANE_W]),
            .order    (in_order),
            .dst_lane (shuf_all[l*LANE_W +: LANE_W])
        );
        if (l == 0) begin : g_lo
            assign next_result[LANE_W-1:0] = shuf_all[LANE_W-1:0];
        end else begin : g_hi
            shuf_hi_mux #(.LANE_W(LANE_W)) u_hi (
                .hi_src       (dec.hi_src),
                .shuf_lane_in (shuf_all[l*LANE_W +: LANE_W]),
                .prev_lane_in (in_prev[l*LANE_W +: LANE_W]),
                .lane_out     (next_result[l*LANE_W +: LANE_W])
            );
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_result  <= '0;
        end else begin
            out_valid   <= in_valid & ~dec.illegal;
            out_illegal <= in_valid & dec.illegal;
            if (in_valid && !dec.illegal) begin
                out_result <= next_result;
            end
        end
    end

    // R6
    bad_mode_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b11) |=> (out_illegal && !out_valid));

    // R6
    hold_on_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> $stable(out_result));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_illegal && $stable(out_result)));

    // R3
    merge_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b00)
        |=> (out_result[DATA_W-1:LANE_W] == $past(in_prev[DATA_W-1:LANE_W])));

    // R4
    zero_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b01 && (&in_rsv))
        |=> (out_result[DATA_W-1:LANE_W] == '0));

endmodule

// File: tb/tb_dw_lane_shuffle.sv
module tb_dw_lane_shuffle;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [255:0] in_src;
    logic [255:0] in_prev;
    logic [7:0]   in_order;
    logic [1:0]   in_mode;
    logic [3:0]   in_rsv;
    logic         out_valid;
    logic         out_illegal;
    logic [255:0] out_result;

    int n_tests = 0;
    int n_fail  = 0;
    logic [255:0] held;

    always #2 clk = ~clk;

    dw_lane_shuffle dut (
        .clk, .rst, .in_valid, .in_src, .in_prev, .in_order,
        .in_mode, .in_rsv, .out_valid, .out_illegal, .out_result
    );

    localparam logic [255:0] SRC_A = {
        32'hB7B7_0007, 32'hB6B6_0006, 32'hB5B5_0005, 32'hB4B4_0004,
        32'hA3A3_0003, 32'hA2A2_0002, 32'hA1A1_0001, 32'hA0A0_0000};
    localparam logic [255:0] SRC_B = {
        32'h1357_9BDF, 32'h2468_ACE0, 32'hDEAD_BEEF, 32'hCAFE_F00D,
        32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'h1234_5678, 32'h8765_4321};
    localparam logic [255:0] PREV_A = {4{64'h5555_AAAA_6666_9999}};

    function automatic logic [255:0] model(input logic [255:0] s, input logic [255:0] p,
                                           input logic [7:0] o, input logic [1:0] m);
        logic [255:0] r;
        for (int l = 0; l < 2; l++) begin
            for (int e = 0; e < 4; e++) begin
                int k;
                k = int'(o[2*e +: 2]);
                r[l*128 + e*32 +: 32] = s[l*128 + k*32 +: 32];
            end
        end
        if (m == 2'b00) r[255:128] = p[255:128];
        else if (m == 2'b01) r[255:128] = '0;
        return r;
    endfunction

    task automatic check_vec(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive one strobe at a falling edge, sample at the next falling edge
    task automatic issue(input logic [255:0] s, input logic [255:0] p,
                         input logic [7:0] o, input logic [1:0] m, input logic [3:0] r);
        @(negedge clk);
        in_src = s; in_prev = p; in_order = o; in_mode = m; in_rsv = r;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic legal_op(input string req, input logic [255:0] s, input logic [255:0] p,
                            input logic [7:0] o, input logic [1:0] m, input logic [3:0] r);
        logic [255:0] exp;
        exp = model(s, p, o, m);
        issue(s, p, o, m, r);
        check_bit({req, " valid"}, out_valid, 1'b1);
        check_bit({req, " illegal"}, out_illegal, 1'b0);
        check_vec({req, " result"}, out_result, exp);
        held = exp;
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0;
        in_src = '0; in_prev = '0; in_order = '0; in_mode = '0; in_rsv = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_bit("R8 valid after reset", out_valid, 1'b0);
        check_bit("R8 illegal after reset", out_illegal, 1'b0);
        check_vec("R8 result after reset", out_result, '0);
        held = '0;
    endtask

    task automatic t_full_patterns();
        legal_op("R1 R2 identity", SRC_A, PREV_A, 8'hE4, 2'b10, 4'hF);
        legal_op("R1 R2 reverse", SRC_A, PREV_A, 8'h1B, 2'b10, 4'hF);
        legal_op("R1 R2 mixed", SRC_B, PREV_A, 8'h8D, 2'b10, 4'hF);
    endtask

    task automatic t_broadcast();
        legal_op("R5 broadcast e0", SRC_B, PREV_A, 8'h00, 2'b10, 4'hF);
        legal_op("R5 broadcast e3", SRC_A, PREV_A, 8'hFF, 2'b10, 4'hF);
        legal_op("R5 repeat pair", SRC_A, PREV_A, 8'h5A, 2'b01, 4'hF);
    endtask

    task automatic t_merge();
        legal_op("R3 merge rsv 0000", SRC_A, PREV_A, 8'h4E, 2'b00, 4'h0);
        legal_op("R3 merge rsv 1010", SRC_B, ~PREV_A, 8'hB1, 2'b00, 4'hA);
    endtask

    task automatic t_zero();
        legal_op("R4 zero upper", SRC_B, PREV_A, 8'h93, 2'b01, 4'hF);
    endtask

    task automatic bad_op(input string req, input logic [1:0] m, input logic [3:0] r);
        issue(SRC_B, ~PREV_A, 8'h27, m, r);
        check_bit({req, " illegal"}, out_illegal, 1'b1);
        check_bit({req, " valid"}, out_valid, 1'b0);
        check_vec({req, " result held"}, out_result, held);
    endtask

    task automatic t_illegal();
        legal_op("R2 setup", SRC_A, PREV_A, 8'h39, 2'b10, 4'hF);
        bad_op("R6 zero rsv 1110", 2'b01, 4'hE);
        bad_op("R6 full rsv 0111", 2'b10, 4'h7);
        bad_op("R6 mode 11", 2'b11, 4'hF);
    endtask

    task automatic t_idle();
        legal_op("R7 setup", SRC_B, PREV_A, 8'hC6, 2'b10, 4'hF);
        in_src = SRC_A; in_order = 8'h00; in_mode = 2'b01;
        @(negedge clk);
        check_bit("R7 idle valid", out_valid, 1'b0);
        check_bit("R7 idle illegal", out_illegal, 1'b0);
        check_vec("R7 idle result held", out_result, held);
    endtask

    task automatic t_reset_midrun();
        legal_op("R8 setup", SRC_A, PREV_A, 8'hE4, 2'b10, 4'hF);
        @(negedge clk);
        in_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        check_bit("R8 valid mid reset", out_valid, 1'b0);
        check_vec("R8 result mid reset", out_result, '0);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_full_patterns();
        t_broadcast();
        t_merge();
        t_zero();
        t_illegal();
        t_idle();
        t_reset_midrun();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule